// File: doc/BRIEF.md
# Privileged Status Word and Banked Stack Pointers

This block keeps a processor's 16-bit status word together with two copies of the stack-pointer register (register 7). One copy serves user mode and the other serves supervisor mode. The supervisor bit of the status word selects which copy the register-7 port reads and writes. Software therefore always sees one stack pointer, and code running in user mode has no path to the supervisor copy.

The block has four write paths. A condition-code write changes only the low byte of the status word and is allowed in either mode. A full status-word write is allowed only in supervisor mode. A dedicated transfer port lets supervisor code load or read the user stack pointer while it runs on its own stack. If user-mode code attempts a privileged operation, the block drops every write of that cycle and raises a one-cycle violation pulse, which the surrounding core turns into an exception. The status word can be read in either mode.

Top module: `priv_state_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, the status word equals 16'h2000 (supervisor bit set), both stack pointers are zero, `supervisor` is 1 and `priv_viol` is 0.
- R2: A write on the register-7 port goes to the supervisor copy when `supervisor` is 1 and to the user copy when it is 0. `sp_rd_data` shows the copy selected by the current mode, and a write is visible there from the cycle after it.
- R3: In either mode, a condition-code write replaces status bits 7:0 with `ccr_wr_data` from the next cycle and leaves bits 15:8 unchanged. When a full status write happens in the same cycle, the full write wins.
- R4: In supervisor mode, a full status write replaces all 16 bits with `sr_wr_data` from the next cycle. `sr_rd_data` always shows the status word, in both modes.
- R5: Bit 13 of the status word is the supervisor bit. Once a status write clears it, the register-7 port uses the user copy from the next cycle. A register-7 write in the same cycle as that status write still goes to the supervisor copy.
- R6: In supervisor mode, a transfer with `usp_xfer_en`=1 and `usp_xfer_wr`=1 loads the user stack pointer from `usp_xfer_wdata`. `usp_rd_data` shows the user stack pointer in supervisor mode and reads zero in user mode.
- R7: In user mode, a full status write or any user-stack transfer (either direction) sets `priv_viol` to 1 in the next cycle only. In that same cycle, every write (register 7, condition code, status, transfer) is dropped.
- R8: The supervisor stack pointer never changes while in user mode, and in user mode `sp_rd_data` never shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_wr_en | input | 1 | Write strobe for register 7 |
| sp_wr_data | input | SP_W | Register-7 write value |
| sp_rd_data | output | SP_W | Stack pointer of the current mode |
| ccr_wr_en | input | 1 | Condition-code (low byte) write strobe |
| ccr_wr_data | input | 8 | Condition-code write value |
| sr_wr_en | input | 1 | Full status write strobe (privileged) |
| sr_wr_data | input | 16 | Full status write value |
| sr_rd_data | output | 16 | Current status word |
| usp_xfer_en | input | 1 | User-stack transfer request (privileged) |
| usp_xfer_wr | input | 1 | 1: load the user stack pointer, 0: read it |
| usp_xfer_wdata | input | SP_W | Value loaded into the user stack pointer |
| usp_rd_data | output | SP_W | User stack pointer (zero in user mode) |
| supervisor | output | 1 | Current mode, 1 = supervisor |
| priv_viol | output | 1 | One-cycle privilege-violation pulse |

## Verification
The bench builds the block with its defaults: SP_W = 32, supervisor bit 13 and reset word 16'h2000. The 32-bit width lets the two stack-pointer copies hold distinct full-width values, so a read that picks the wrong copy cannot match the expected value. The default reset word is what allows a status write of 16'h0000 or 16'h0715 to drop the block into user mode. From there, the rejected-write paths and the same-cycle ordering between the status and register-7 writes can be reached.

// File: rtl/priv_state_regs.sv
module priv_state_regs #(
  parameter int          SP_W     = 32,
  parameter int          S_BIT    = 13,
  parameter logic [15:0] SR_RESET = 16'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_wr_en,
  input  logic [SP_W-1:0] sp_wr_data,
  output logic [SP_W-1:0] sp_rd_data,
  input  logic            ccr_wr_en,
  input  logic [7:0]      ccr_wr_data,
  input  logic            sr_wr_en,
  input  logic [15:0]     sr_wr_data,
  output logic [15:0]     sr_rd_data,
  input  logic            usp_xfer_en,
  input  logic            usp_xfer_wr,
  input  logic [SP_W-1:0] usp_xfer_wdata,
  output logic [SP_W-1:0] usp_rd_data,
  output logic            supervisor,
  output logic            priv_viol
);

  logic [15:0]     sr_q;
  logic [SP_W-1:0] usp_q;
  logic [SP_W-1:0] ssp_q;
  logic            viol_q;

  wire super_m = sr_q[S_BIT];
  wire attempt_bad = !super_m && (sr_wr_en || usp_xfer_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= SR_RESET;
      usp_q  <= '0;
      ssp_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= attempt_bad;
      if (!attempt_bad) begin
        if (sr_wr_en)
          sr_q <= sr_wr_data;
        else if (ccr_wr_en)
          sr_q[7:0] <= ccr_wr_data;
        if (sp_wr_en) begin
          if (super_m) ssp_q <= sp_wr_data;
          else         usp_q <= sp_wr_data;
        end
        if (usp_xfer_en && usp_xfer_wr)
          usp_q <= usp_xfer_wdata;
      end
    end
  end

  assign sp_rd_data  = super_m ? ssp_q : usp_q;
  assign usp_rd_data = super_m ? usp_q : '0;
  assign sr_rd_data  = sr_q;
  assign supervisor  = super_m;
  assign priv_viol   = viol_q;

  assert_ccr_high_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr_en && !sr_wr_en) |=> (sr_rd_data[15:8] == $past(sr_rd_data[15:8])));

  assert_user_sr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!supervisor && (sr_wr_en || usp_xfer_en)) |=> ($stable(sr_rd_data) && priv_viol));

  assert_viol_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_viol && !$past(!supervisor && (sr_wr_en || usp_xfer_en))) |-> 1'b0);

  assert_ssp_frozen_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supervisor |=> $stable(ssp_q));

  assert_user_port_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !supervisor |-> (usp_rd_data == '0));

  assert_sup_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (supervisor && sp_wr_en) |=> (ssp_q == $past(sp_wr_data)));

endmodule

// File: tb/priv_state_regs_test.sv
module priv_state_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_wr_en = 0, ccr_wr_en = 0, sr_wr_en = 0, usp_xfer_en = 0, usp_xfer_wr = 0;
  logic [31:0] sp_wr_data = '0, usp_xfer_wdata = '0;
  logic [7:0]  ccr_wr_data = '0;
  logic [15:0] sr_wr_data = '0;
  logic [31:0] sp_rd_data, usp_rd_data;
  logic [15:0] sr_rd_data;
  logic        supervisor, priv_viol;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  priv_state_regs uut (
    .clk(clk), .rst_n(rst_n),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data),
    .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
    .usp_xfer_en(usp_xfer_en), .usp_xfer_wr(usp_xfer_wr), .usp_xfer_wdata(usp_xfer_wdata),
    .usp_rd_data(usp_rd_data), .supervisor(supervisor), .priv_viol(priv_viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // op: 0 idle, 1 reg7 write, 2 ccr write, 3 sr write, 4 usp load, 5 usp read
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [15:0] exp_sr;
    logic [31:0] exp_sp;
    logic        exp_viol;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h1000_0000, 16'h2000, 32'h1000_0000, 1'b0},
    '{3'd4, 32'h2000_0000, 16'h2000, 32'h1000_0000, 1'b0},
    '{3'd2, 32'h0000_00FF, 16'h20FF, 32'h1000_0000, 1'b0},
    '{3'd3, 32'h0000_0715, 16'h0715, 32'h2000_0000, 1'b0},
    '{3'd1, 32'h3000_0000, 16'h0715, 32'h3000_0000, 1'b0},
    '{3'd2, 32'h0000_00AA, 16'h07AA, 32'h3000_0000, 1'b0},
    '{3'd3, 32'h0000_2000, 16'h07AA, 32'h3000_0000, 1'b1},
    '{3'd4, 32'h0000_4444, 16'h07AA, 32'h3000_0000, 1'b1},
    '{3'd5, 32'h0000_0000, 16'h07AA, 32'h3000_0000, 1'b1},
    '{3'd0, 32'h0000_0000, 16'h07AA, 32'h3000_0000, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    sp_wr_en = 0; ccr_wr_en = 0; sr_wr_en = 0; usp_xfer_en = 0; usp_xfer_wr = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 state held in reset
    chk("R1", "sr in reset", {16'h0, sr_rd_data}, 32'h2000);
    chk("R1", "sp in reset", sp_rd_data, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1", "sr after reset", {16'h0, sr_rd_data}, 32'h2000);
    chk("R1", "sp after reset", sp_rd_data, 32'h0);
    chk("R1", "usp after reset", usp_rd_data, 32'h0);
    chk("R1", "mode after reset", {31'h0, supervisor}, 32'h1);
    chk("R1", "viol after reset", {31'h0, priv_viol}, 32'h0);

    // Table walk: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      clear_inputs();
      case (VECS[i].op)
        3'd1: begin sp_wr_en = 1; sp_wr_data = VECS[i].data; end
        3'd2: begin ccr_wr_en = 1; ccr_wr_data = VECS[i].data[7:0]; end
        3'd3: begin sr_wr_en = 1; sr_wr_data = VECS[i].data[15:0]; end
        3'd4: begin usp_xfer_en = 1; usp_xfer_wr = 1; usp_xfer_wdata = VECS[i].data; end
        3'd5: begin usp_xfer_en = 1; usp_xfer_wr = 0; end
        default: ;
      endcase
      tick();
      chk("R2/R3/R4/R5", $sformatf("vec %0d sr", i), {16'h0, sr_rd_data}, {16'h0, VECS[i].exp_sr});
      chk("R2/R5/R8", $sformatf("vec %0d sp", i), sp_rd_data, VECS[i].exp_sp);
      chk("R7", $sformatf("vec %0d viol", i), {31'h0, priv_viol}, {31'h0, VECS[i].exp_viol});
    end
    clear_inputs();

    // Directed tests from a fresh reset
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "sp after second reset", sp_rd_data, 32'h0);

    usp_xfer_en = 1; usp_xfer_wr = 1; usp_xfer_wdata = 32'hCAFE_0001;
    tick(); clear_inputs();
    chk("R6", "usp load in supervisor", usp_rd_data, 32'hCAFE_0001);
    chk("R6", "reg7 still supervisor copy", sp_rd_data, 32'h0);

    sr_wr_en = 1; sr_wr_data = 16'h2300; ccr_wr_en = 1; ccr_wr_data = 8'h55;
    tick(); clear_inputs();
    chk("R3", "sr beats ccr same cycle", {16'h0, sr_rd_data}, 32'h2300);

    sr_wr_en = 1; sr_wr_data = 16'h0000; sp_wr_en = 1; sp_wr_data = 32'h5555_0000;
    tick(); clear_inputs();
    chk("R5", "mode cleared", {31'h0, supervisor}, 32'h0);
    chk("R5", "reg7 now user copy", sp_rd_data, 32'hCAFE_0001);
    chk("R6", "usp port hidden in user", usp_rd_data, 32'h0);

    sr_wr_en = 1; sr_wr_data = 16'h2000; sp_wr_en = 1; sp_wr_data = 32'h6666_0000;
    ccr_wr_en = 1; ccr_wr_data = 8'h0F;
    tick(); clear_inputs();
    chk("R7", "violation raised", {31'h0, priv_viol}, 32'h1);
    chk("R7", "sr unchanged on violation", {16'h0, sr_rd_data}, 32'h0);
    chk("R7", "reg7 write dropped", sp_rd_data, 32'hCAFE_0001);
    chk("R8", "still user mode", {31'h0, supervisor}, 32'h0);

    tick();
    chk("R7", "violation lasts one cycle", {31'h0, priv_viol}, 32'h0);

    sp_wr_en = 1; sp_wr_data = 32'h7777_0000;
    tick(); clear_inputs();
    chk("R2", "user reg7 write", sp_rd_data, 32'h7777_0000);
    chk("R8", "no violation on reg7 write", {31'h0, priv_viol}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule